// File: doc/BRIEF.md
# Serial Chien Search and Forney Error Corrector

This block closes a hard-decision Reed-Solomon decoder. It takes the error locator polynomial and the error evaluator polynomial from a key-equation stage. It also takes the received word, one symbol per handshake, and returns the corrected word in the same order. One register per polynomial term is multiplied by a fixed power of the primitive element on every accepted symbol, so the locator and the evaluator are evaluated at one field point per symbol. A position is an error when the locator sum is zero. The error magnitude there is the evaluator value divided by the sum of the odd-index locator terms, and that divisor comes from the same term registers that the root test uses. The magnitude is XORed onto the symbol as it passes through.

A word begins with a one-cycle `start` that samples both coefficient buses. Symbols then flow in over a valid/ready input and out over a valid/ready output that has one register stage. A transfer takes place on a clock edge where valid and ready are both high. The output holds its symbol while `out_ready` is low. `in_ready` is low whenever the output register is full and not being drained in that cycle, so back-pressure passes straight through to the input. After the last symbol, `word_done` pulses. `fail` then reports whether the number of roots found differs from the locator degree, and it keeps that value until the next `start`. Corrections are applied as the roots are found, and a failed word is not withheld.

Top module: `rs_chien_forney`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid`, `in_ready`, `word_done` and `fail` are all 0.
- R2: `in_ready` is 0 unless a word is in progress and `start` is low. A word begins at the clock edge where `start` is high. It accepts exactly N = 2^M-1 symbols, and after the N-th accepted symbol `in_ready` stays 0 until the next `start`.
- R3: Symbols arrive with the highest position first. The k-th accepted symbol (k = 0..N-1) is position N-1-k. For it the locator is evaluated at alpha^(k+1), which is the inverse of alpha^(N-1-k). The symbol is flagged as an error exactly when that evaluation is zero.
- R4: The locator is sum lambda_j z^j, with coefficient j at bits [j*M +: M] of `lambda_coefs` (j = 0..T). The evaluator is sum omega_j z^j, with coefficient j at bits [j*M +: M] of `omega_coefs` (j = 0..T-1). At a flagged position the output is the received symbol XOR omega(x) / D(x), where D(x) is the sum of lambda_j x^j over odd j. This is the correct magnitude when the syndromes are S_i = R(alpha^i) for i = 0..2T-1 and omega = lambda*S mod z^(2T). Unflagged symbols pass through unchanged.
- R5: Arithmetic is in GF(2^M) generated by the primitive polynomial POLY, which includes the x^M term. The primitive element alpha is the element x, that is the value 2.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_sym` hold at the next edge and `in_ready` is 0. Each accepted input yields exactly one output, in order.
- R7: `word_done` is high for exactly one cycle. That cycle follows the edge that accepts the N-th symbol, and it is the cycle in which the N-th corrected symbol first appears on the output.
- R8: `fail` becomes valid together with `word_done`. It is 1 when the number of flagged positions in the word differs from the locator degree, the highest index j with a nonzero lambda_j. It is 0 while a word is in progress and holds its value until the next `start`.
- R9: When a flagged position has D(x) = 0, division by zero gives a magnitude of zero, so that symbol passes unchanged.
- R10: A `start` during a word abandons that word. It discards any output symbol still waiting, produces no `word_done` for the old word, and begins a new N-symbol word with the new coefficients.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse: sample coefficients and begin a word |
| lambda_coefs | input | (T+1)*M | Error locator coefficients, lambda_j at [j*M +: M] |
| omega_coefs | input | T*M | Error evaluator coefficients, omega_j at [j*M +: M] |
| in_valid | input | 1 | Received symbol available |
| in_ready | output | 1 | Block accepts a received symbol |
| in_sym | input | M | Received symbol |
| out_valid | output | 1 | Corrected symbol available |
| out_ready | input | 1 | Downstream accepts the corrected symbol |
| out_sym | output | M | Corrected symbol |
| word_done | output | 1 | One-cycle pulse after the last symbol of a word |
| fail | output | 1 | Root count differs from locator degree |

## Verification
The bench builds the block with M = 4, T = 2 and POLY = x^4+x+1, so a word is 15 symbols long. This small field makes exhaustive sweeps cheap. The bench tries every single error at every position with every nonzero magnitude, and every pair of error positions. It also sweeps all 256 locators with a unit constant term. That sweep covers locators without roots, locators with a repeated root (zero derivative), and locators whose root count falls short of their degree. All expected symbols and flags come from log/antilog arithmetic inside the bench. Words with random input gaps and output stalls, and a word abandoned halfway, exercise the handshake and the restart rule.

// File: rtl/rs_chien_pkg.sv
package rs_chien_pkg;

  localparam int unsigned GF_MAXW = 16;

  typedef logic [GF_MAXW-1:0] gf_word_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  // Shift-and-add product in GF(2^m); poly carries the x^m bit.
  function automatic gf_word_t gf_mul_fn(gf_word_t a, gf_word_t b, int unsigned m, gf_word_t poly);
    gf_word_t acc;
    gf_word_t sh;
    acc = '0;
    sh  = a;
    for (int unsigned i = 0; i < GF_MAXW; i++) begin
      if (i < m) begin
        if (b[i]) acc = acc ^ sh;
        sh = sh << 1;
        if (sh[m]) sh = sh ^ poly;
      end
    end
    return acc;
  endfunction

  // alpha^e with alpha = x.
  function automatic gf_word_t gf_alpha_pow(int unsigned e, int unsigned m, gf_word_t poly);
    gf_word_t v;
    v = gf_word_t'(1);
    for (int unsigned k = 0; k < e; k++) begin
      v = v << 1;
      if (v[m]) v = v ^ poly;
    end
    return v;
  endfunction

  // Multiplicative inverse by walking the powers of alpha; zero maps to zero.
  function automatic gf_word_t gf_inv_fn(gf_word_t v, int unsigned m, gf_word_t poly);
    gf_word_t    p;
    int unsigned n;
    int unsigned k;
    bit          hit;
    if (v == '0) return '0;
    n   = (1 << m) - 1;
    p   = gf_word_t'(1);
    k   = 0;
    hit = 1'b0;
    for (int unsigned s = 0; s < n; s++) begin
      if (!hit) begin
        if (p == v) hit = 1'b1;
        else begin
          p = p << 1;
          if (p[m]) p = p ^ poly;
          k = k + 1;
        end
      end
    end
    return gf_alpha_pow((n - k) % n, m, poly);
  endfunction

endpackage

// File: rtl/rs_gf_mul.sv
module rs_gf_mul #(
  parameter int unsigned M    = 8,
  parameter int unsigned POLY = 'h11D
) (
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] p
);

  localparam logic [M-1:0] RED = M'(POLY);

  // sh[i] = a * x^i reduced
  logic [M-1:0] sh [M];

  assign sh[0] = a;

  for (genvar i = 1; i < M; i++) begin : g_shift
    assign sh[i] = {sh[i-1][M-2:0], 1'b0} ^ (sh[i-1][M-1] ? RED : '0);
  end

  always_comb begin
    p = '0;
    for (int unsigned i = 0; i < M; i++) begin
      if (b[i]) p = p ^ sh[i];
    end
  end

endmodule

// File: rtl/rs_gf_inv_lut.sv
module rs_gf_inv_lut #(
  parameter int unsigned M    = 8,
  parameter int unsigned POLY = 'h11D
) (
  input  logic [M-1:0] a,
  output logic [M-1:0] y
);
  import rs_chien_pkg::*;

  localparam int unsigned SIZE = 1 << M;

  logic [M-1:0] tab [SIZE];

  for (genvar gv = 0; gv < SIZE; gv++) begin : g_entry
    localparam gf_word_t INV_V = gf_inv_fn(GF_MAXW'(gv), M, GF_MAXW'(POLY));
    assign tab[gv] = INV_V[M-1:0];
  end

  assign y = tab[a];

endmodule

// File: rtl/rs_chien_cell.sv
module rs_chien_cell #(
  parameter int unsigned M    = 8,
  parameter int unsigned POLY = 'h11D,
  parameter int unsigned J    = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [M-1:0] coef,
  output logic [M-1:0] term
);
  import rs_chien_pkg::*;

  localparam gf_word_t     MULT_W = gf_alpha_pow(J, M, GF_MAXW'(POLY));
  localparam logic [M-1:0] MULT   = MULT_W[M-1:0];

  logic [M-1:0] mul_in;
  logic [M-1:0] mul_out;

  // One constant multiplier serves both the load (first point) and each step.
  assign mul_in = load ? coef : term;

  rs_gf_mul #(.M(M), .POLY(POLY)) u_mul (
    .a(mul_in),
    .b(MULT),
    .p(mul_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            term <= '0;
    else if (load || step) term <= mul_out;
  end

endmodule

// File: rtl/rs_chien_forney.sv
module rs_chien_forney #(
  parameter int unsigned M    = 8,
  parameter int unsigned T    = 8,
  parameter int unsigned POLY = 'h11D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [(T+1)*M-1:0] lambda_coefs,
  input  logic [T*M-1:0]   omega_coefs,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [M-1:0]     in_sym,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [M-1:0]     out_sym,
  output logic             word_done,
  output logic             fail
);
  import rs_chien_pkg::*;

  localparam int unsigned    N    = (1 << M) - 1;
  localparam int unsigned    CW   = $clog2(N + 1);
  localparam logic [CW-1:0]  LAST = CW'(N - 1);

  run_state_e    state_q;
  logic [CW-1:0] sym_cnt;
  logic [CW-1:0] root_cnt;
  logic [CW-1:0] deg_q;
  logic [CW-1:0] deg_c;
  logic          accept;
  logic          step;

  logic [M-1:0]  lam_t [T+1];
  logic [M-1:0]  om_t  [T];
  logic [M-1:0]  lam_sum;
  logic [M-1:0]  odd_sum;
  logic [M-1:0]  om_sum;
  logic [M-1:0]  inv_val;
  logic [M-1:0]  err_mag;
  logic          is_root;
  logic [M-1:0]  corr;

  // ---------------- handshake ----------------
  assign in_ready = (state_q == ST_RUN) && !start && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;
  assign step     = accept;

  // ---------------- term registers ----------------
  for (genvar j = 0; j <= T; j++) begin : g_lam
    rs_chien_cell #(.M(M), .POLY(POLY), .J(j)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .load (start),
      .step (step),
      .coef (lambda_coefs[j*M +: M]),
      .term (lam_t[j])
    );
  end

  for (genvar j = 0; j < T; j++) begin : g_om
    rs_chien_cell #(.M(M), .POLY(POLY), .J(j)) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .load (start),
      .step (step),
      .coef (omega_coefs[j*M +: M]),
      .term (om_t[j])
    );
  end

  // ---------------- evaluation sums ----------------
  always_comb begin
    lam_sum = '0;
    odd_sum = '0;
    om_sum  = '0;
    for (int unsigned j = 0; j <= T; j++) begin
      lam_sum = lam_sum ^ lam_t[j];
      if ((j % 2) == 1) odd_sum = odd_sum ^ lam_t[j];
    end
    for (int unsigned j = 0; j < T; j++) begin
      om_sum = om_sum ^ om_t[j];
    end
  end

  // ---------------- Forney division ----------------
  rs_gf_inv_lut #(.M(M), .POLY(POLY)) u_inv (
    .a(odd_sum),
    .y(inv_val)
  );

  rs_gf_mul #(.M(M), .POLY(POLY)) u_mag (
    .a(om_sum),
    .b(inv_val),
    .p(err_mag)
  );

  assign is_root = (lam_sum == '0);
  assign corr    = is_root ? err_mag : '0;

  // ---------------- locator degree ----------------
  always_comb begin
    deg_c = '0;
    for (int unsigned j = 1; j <= T; j++) begin
      if (lambda_coefs[j*M +: M] != '0) deg_c = CW'(j);
    end
  end

  // ---------------- word control ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sym_cnt   <= '0;
      root_cnt  <= '0;
      deg_q     <= '0;
      word_done <= 1'b0;
      fail      <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (start) begin
        state_q  <= ST_RUN;
        sym_cnt  <= '0;
        root_cnt <= '0;
        deg_q    <= deg_c;
        fail     <= 1'b0;
      end else if (accept) begin
        root_cnt <= root_cnt + CW'(is_root);
        if (sym_cnt == LAST) begin
          state_q   <= ST_IDLE;
          sym_cnt   <= '0;
          word_done <= 1'b1;
          fail      <= ((root_cnt + CW'(is_root)) != deg_q);
        end else begin
          sym_cnt <= sym_cnt + CW'(1);
        end
      end
    end
  end

  // ---------------- output stage ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sym   <= '0;
    end else if (start) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_sym   <= in_sym ^ corr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // ---------------- assertions ----------------
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_sym)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);

  // R8
  fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> !fail);

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (sym_cnt == '0));

  // R9
  inv_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_sum != '0) |->
      (gf_mul_fn(GF_MAXW'(odd_sum), GF_MAXW'(inv_val), M, GF_MAXW'(POLY)) == GF_MAXW'(1)));

  // R9
  inv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_sum == '0) |-> (inv_val == '0));

endmodule

// File: tb/rs_chien_forney_bench.sv
module rs_chien_forney_bench;

  localparam int MB = 4;
  localparam int TB = 2;
  localparam int PB = 'h13;
  localparam int NB = 15;
  localparam int CLK_PERIOD = 10;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  start = 1'b0;
  logic [(TB+1)*MB-1:0]  lambda_coefs = '0;
  logic [TB*MB-1:0]      omega_coefs = '0;
  logic                  in_valid = 1'b0;
  logic                  in_ready;
  logic [MB-1:0]         in_sym = '0;
  logic                  out_valid;
  logic                  out_ready = 1'b0;
  logic [MB-1:0]         out_sym;
  logic                  word_done;
  logic                  fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_chien_forney #(.M(MB), .T(TB), .POLY(PB)) u_rs_chien_forney (
    .clk(clk), .rst_n(rst_n), .start(start),
    .lambda_coefs(lambda_coefs), .omega_coefs(omega_coefs),
    .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
    .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym),
    .word_done(word_done), .fail(fail)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] rng = 32'h1234_5677;

  int exp_t [NB];
  int log_t [NB+1];

  int lam [TB+1];
  int om  [TB];
  int word_in [NB];
  int exp_out [NB];
  int err_at  [NB];
  int exp_fail;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic rnd(output logic [31:0] r);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    r = rng;
  endtask

  function automatic int gmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return exp_t[(log_t[a] + log_t[b]) % NB];
  endfunction

  function automatic int ginv(int a);
    if (a == 0) return 0;
    return exp_t[(NB - log_t[a]) % NB];
  endfunction

  function automatic int apow(int e);
    return exp_t[e % NB];
  endfunction

  function automatic int poly_at(int x, bit use_om, bit odd_only);
    int acc = 0;
    int xp = 1;
    int cnt = use_om ? TB : TB + 1;
    for (int j = 0; j < cnt; j++) begin
      if (use_om) acc = acc ^ gmul(om[j], xp);
      else if (!odd_only || (j % 2 == 1)) acc = acc ^ gmul(lam[j], xp);
      xp = gmul(xp, x);
    end
    return acc;
  endfunction

  // Expected outputs from a known error pattern (R3, R4)
  task automatic expect_from_errors();
    int s [2*TB];
    int nl [TB+1];
    for (int j = 0; j <= TB; j++) lam[j] = (j == 0) ? 1 : 0;
    for (int p = 0; p < NB; p++) begin
      if (err_at[p] != 0) begin
        for (int j = 0; j <= TB; j++)
          nl[j] = lam[j] ^ ((j > 0) ? gmul(apow(p), lam[j-1]) : 0);
        for (int j = 0; j <= TB; j++) lam[j] = nl[j];
      end
    end
    for (int i = 0; i < 2*TB; i++) begin
      s[i] = 0;
      for (int p = 0; p < NB; p++) s[i] = s[i] ^ gmul(err_at[p], apow(p*i));
    end
    for (int j = 0; j < TB; j++) begin
      om[j] = 0;
      for (int i = 0; i <= j; i++) om[j] = om[j] ^ gmul(lam[i], s[j-i]);
    end
    for (int k = 0; k < NB; k++) exp_out[k] = word_in[k] ^ err_at[NB-1-k];
    exp_fail = 0;
  endtask

  // Expected outputs for arbitrary coefficients (R3, R4, R8, R9)
  task automatic expect_generic();
    int roots = 0;
    int deg = 0;
    for (int j = 1; j <= TB; j++) if (lam[j] != 0) deg = j;
    for (int k = 0; k < NB; k++) begin
      int x = apow(k + 1);
      if (poly_at(x, 1'b0, 1'b0) == 0) begin
        roots++;
        exp_out[k] = word_in[k] ^ gmul(poly_at(x, 1'b1, 1'b0), ginv(poly_at(x, 1'b0, 1'b1)));
      end else begin
        exp_out[k] = word_in[k];
      end
    end
    exp_fail = (roots != deg) ? 1 : 0;
  endtask

  task automatic random_word();
    logic [31:0] r;
    for (int k = 0; k < NB; k++) begin
      rnd(r);
      word_in[k] = int'(r[3:0]);
    end
  endtask

  task automatic clear_errors();
    for (int p = 0; p < NB; p++) err_at[p] = 0;
  endtask

  task automatic issue_start();
    @(negedge clk);
    start = 1'b1;
    in_valid = 1'b0;
    out_ready = 1'b0;
    for (int j = 0; j <= TB; j++) lambda_coefs[j*MB +: MB] = MB'(lam[j]);
    for (int j = 0; j < TB; j++) omega_coefs[j*MB +: MB] = MB'(om[j]);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_word(input bit stall, input string req);
    logic [31:0] r;
    int ii = 0;
    int oi = 0;
    int cyc = 0;
    int dones = 0;
    bit hold_pend = 1'b0;
    int held = 0;
    issue_start();
    while (oi < NB && cyc < 3000) begin
      rnd(r);
      in_valid  = (ii < NB) && (!stall || r[0]);
      in_sym    = in_valid ? MB'(word_in[ii]) : MB'(r[7:4]);
      out_ready = !stall || (r[2:1] != 2'b00);
      #1;
      if (hold_pend) begin
        chk(out_valid == 1'b1, "R6 hold valid", int'(out_valid), 1);
        chk(int'(out_sym) == held, "R6 hold data", int'(out_sym), held);
      end
      hold_pend = out_valid && !out_ready;
      held = int'(out_sym);
      if (hold_pend) chk(in_ready == 1'b0, "R6 in_ready under stall", int'(in_ready), 0);
      if (word_done) begin
        dones++;
        chk(int'(fail) == exp_fail, {req, " R8 fail"}, int'(fail), exp_fail);
        chk(oi == NB - 1 && out_valid, "R7 done timing", oi, NB - 1);
      end
      if (in_valid && in_ready) ii++;
      if (out_valid && out_ready) begin
        chk(int'(out_sym) == exp_out[oi], {req, " symbol"}, int'(out_sym), exp_out[oi]);
        oi++;
      end
      @(negedge clk);
      cyc++;
    end
    chk(oi == NB, "R2 word length", oi, NB);
    chk(dones == 1, "R7 done count", dones, 1);
    in_valid = 1'b0;
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R2 ready after word", int'(in_ready), 0);
    chk(int'(fail) == exp_fail, "R8 fail held", int'(fail), exp_fail);
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int v;
    v = 1;
    for (int i = 0; i < NB; i++) begin
      exp_t[i] = v;
      log_t[v] = i;
      v = v << 1;
      if ((v & 16) != 0) v = v ^ PB;
    end
    log_t[0] = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);
    chk(word_done == 1'b0, "R1 word_done", int'(word_done), 0);
    chk(fail == 1'b0, "R1 fail", int'(fail), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b0 && word_done == 1'b0 && fail == 1'b0,
        "R1 after release", int'(out_valid), 0);

    // R2: nothing accepted without a word in progress
    in_valid = 1'b1;
    out_ready = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R2 idle ready", int'(in_ready), 0);
      chk(out_valid == 1'b0, "R2 idle output", int'(out_valid), 0);
    end
    in_valid = 1'b0;

    // R4: error-free words pass unchanged
    for (int w = 0; w < 4; w++) begin
      random_word();
      clear_errors();
      expect_from_errors();
      run_word(1'b0, "R4 clean");
    end

    // R3 R4 R5: every single error, every magnitude
    for (int p = 0; p < NB; p++) begin
      for (int e = 1; e < 16; e++) begin
        random_word();
        clear_errors();
        err_at[p] = e;
        expect_from_errors();
        run_word(1'b0, "R3 single");
      end
    end

    // R3 R4: every pair of error positions
    for (int p = 0; p < NB; p++) begin
      for (int q = p + 1; q < NB; q++) begin
        for (int rep = 0; rep < 2; rep++) begin
          random_word();
          clear_errors();
          rnd(r);
          err_at[p] = (int'(r[3:0]) % 15) + 1;
          err_at[q] = (int'(r[7:4]) % 15) + 1;
          expect_from_errors();
          run_word(1'b0, "R4 double");
        end
      end
    end

    // R6: random gaps and output stalls
    for (int w = 0; w < 24; w++) begin
      random_word();
      clear_errors();
      rnd(r);
      err_at[int'(r[3:0]) % NB] = (int'(r[7:4]) % 15) + 1;
      if (r[8]) err_at[int'(r[15:12]) % NB] = (int'(r[11:9]) % 7) + 1;
      expect_from_errors();
      run_word(1'b1, "R6 stalled");
    end

    // R8 R9: sweep all locators with unit constant term
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        random_word();
        rnd(r);
        lam[0] = 1;
        lam[1] = a;
        lam[2] = b;
        om[0] = int'(r[3:0]);
        om[1] = int'(r[7:4]);
        expect_generic();
        run_word(1'b0, "R8 R9 sweep");
      end
    end

    // R9: repeated root 1 + alpha^6 z^2 -> root at position 3 (k = 11), zero derivative
    random_word();
    lam[0] = 1; lam[1] = 0; lam[2] = apow(6);
    om[0] = 5; om[1] = 9;
    expect_generic();
    chk(exp_out[11] == word_in[11] && exp_fail == 1, "R9 model", exp_fail, 1);
    run_word(1'b0, "R9 repeated root");

    // R10: abandon a word halfway, then run a new one
    random_word();
    clear_errors();
    err_at[10] = 7;
    expect_from_errors();
    issue_start();
    begin
      int fed = 0;
      while (fed < 7) begin
        in_valid = 1'b1;
        in_sym = MB'(word_in[fed]);
        out_ready = 1'b1;
        #1;
        chk(word_done == 1'b0, "R10 no done in partial", int'(word_done), 0);
        if (in_ready) fed++;
        @(negedge clk);
      end
      in_valid = 1'b0;
    end
    random_word();
    clear_errors();
    err_at[2] = 3;
    err_at[13] = 12;
    expect_from_errors();
    run_word(1'b0, "R10 restart");
    #1;
    chk(out_valid == 1'b0, "R10 no stray output", int'(out_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule